// File: doc/BRIEF.md
# Burst Job Splitter

The block takes byte-addressed memory jobs on a valid/ready input stream. Each job is a start address, a length in bytes and an ID. It turns each job into a series of smaller jobs on a valid/ready output stream, and each output job is a legal memory burst. No output job is longer than `MAX_OUT` bytes. `MAX_OUT` is a power of two from 2 to 4096. No output job crosses a `MAX_OUT`-aligned address, so none can cross a 4 KiB boundary.

The first piece of a job runs from the start address up to the next `MAX_OUT`-aligned address, or to the end of the job if that comes first. Every following piece is `MAX_OUT` bytes long, except the last one, which carries whatever remains. Because the pieces after the first always start on an aligned address, no separate 4 KiB boundary comparison is needed. The block handles one input job at a time.

Back-pressure works as follows. The input is accepted on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only while no job is being split. The output holds `out_valid` and all of its fields unchanged until `out_ready` is seen high. Two single-cycle flags report inputs that are too long or have zero length. Reset is asynchronous and active low.

Top module: `job_splitter`

## Requirements
- R1: Every output job has `out_len` <= `MAX_OUT`.
- R2: No output job crosses a `MAX_OUT`-aligned address. Therefore `(out_addr mod 4096) + out_len` <= 4096 holds for every output job.
- R3: The first piece of an input job starts at the input address. Its length is min(length, `MAX_OUT` - (address mod `MAX_OUT`)).
- R4: Each later piece starts where the previous piece ended. Its length is min(remaining, `MAX_OUT`). The lengths of all pieces add up to the input length.
- R5: Every output piece carries the ID of the input job it came from.
- R6: `in_ready` is 1 while the block is idle. It is 0 from the cycle after a job is accepted until the cycle after its last piece is accepted.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_addr`, `out_len` and `out_id` stay unchanged in the next cycle.
- R8: With `REMOVE_ZERO` = 1, a zero-length input job is accepted and produces no output job. `in_ready` stays 1.
- R9: With `REMOVE_ZERO` = 0, a zero-length input job produces a single output job of length 0 at its address. `err_zero_len` is 1 for exactly the one cycle after that job is accepted.
- R10: With `REMOVE_ZERO` = 1, `err_zero_len` is always 0.
- R11: `err_too_long` is 1 for exactly the one cycle after an input job with length > `MAX_IN` is accepted. That job is still split normally.
- R12: While reset is held and right after it is released, `out_valid` = 0, `in_ready` = 1, and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input job valid |
| in_ready | output | 1 | Input job accepted when high together with in_valid |
| in_addr | input | ADDR_W | Start byte address of the input job |
| in_len | input | LEN_W | Input job length in bytes |
| in_id | input | ID_W | Input job ID |
| out_valid | output | 1 | Output piece valid |
| out_ready | input | 1 | Downstream accepts the output piece |
| out_addr | output | ADDR_W | Start byte address of the piece |
| out_len | output | $clog2(MAX_OUT)+1 | Piece length in bytes |
| out_id | output | ID_W | ID copied from the input job |
| err_too_long | output | 1 | One-cycle pulse: the accepted job was longer than MAX_IN |
| err_zero_len | output | 1 | One-cycle pulse: the accepted job had zero length (removal off) |

## Verification
The bench builds the block with `MAX_OUT` = 16, `MAX_IN` = 100, a 7-bit length and a 14-bit address. It uses two instances, one with `REMOVE_ZERO` = 0 and one with `REMOVE_ZERO` = 1.

On the first instance, the bench sweeps every start offset in two 32-byte windows, one at address 0 and one just below 4096. For each offset it tries every length from 0 to 40, plus lengths on both sides of `MAX_IN` and the largest length. Together these cover:
- every alignment of the first piece
- single-piece, two-piece and multi-piece jobs
- jobs that end exactly on an aligned address
- the 4 KiB edge
- both error flags

A repeating `out_ready` pattern stalls pieces in the middle of a job. The second instance covers zero-length removal.

// File: rtl/jp_pkg.sv
package jp_pkg;
  function automatic int unsigned jp_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/jp_piece_calc.sv
module jp_piece_calc #(
  parameter int MAX_OUT = 256,
  parameter int LEN_W   = 16,
  localparam int OFS_W  = $clog2(MAX_OUT),
  localparam int PW     = OFS_W + 1
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic [LEN_W-1:0] remain,
  output logic [PW-1:0]    piece,
  output logic             last
);
  localparam int CW = jp_pkg::jp_max(LEN_W, PW);

  logic [PW-1:0] to_bnd;
  logic [CW-1:0] rem_w, bnd_w;

  always_comb begin
    to_bnd = PW'(MAX_OUT) - {1'b0, ofs};
    rem_w  = CW'(remain);
    bnd_w  = CW'(to_bnd);
    if (rem_w <= bnd_w) begin
      piece = PW'(rem_w);
      last  = 1'b1;
    end else begin
      piece = to_bnd;
      last  = 1'b0;
    end
  end
endmodule

// File: rtl/jp_job_state.sv
module jp_job_state #(
  parameter int ADDR_W  = 32,
  parameter int ID_W    = 4,
  parameter int LEN_W   = 16,
  parameter int MAX_OUT = 256,
  localparam int OFS_W  = $clog2(MAX_OUT),
  localparam int PW     = OFS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic [ID_W-1:0]   ld_id,
  input  logic              fire,
  input  logic [PW-1:0]     piece,
  input  logic              last,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  remain,
  output logic [ID_W-1:0]   cur_id
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_addr <= '0;
      remain   <= '0;
      cur_id   <= '0;
    end else if (load) begin
      busy     <= 1'b1;
      cur_addr <= ld_addr;
      remain   <= ld_len;
      cur_id   <= ld_id;
    end else if (fire) begin
      cur_addr <= cur_addr + ADDR_W'(piece);
      remain   <= remain - LEN_W'(piece);
      if (last) busy <= 1'b0;
    end
  end

  // R4
  piece_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !last |=> busy && (cur_addr[OFS_W-1:0] == '0));

  // R6
  last_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && last && !load |=> !busy);
endmodule

// File: rtl/jp_err_flags.sv
module jp_err_flags #(
  parameter int LEN_W       = 16,
  parameter int MAX_IN      = 65535,
  parameter bit REMOVE_ZERO = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [LEN_W-1:0] len,
  output logic             err_too_long,
  output logic             err_zero_len
);
  localparam logic [LEN_W-1:0] MAX_IN_L = LEN_W'(MAX_IN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_too_long <= 1'b0;
      err_zero_len <= 1'b0;
    end else begin
      err_too_long <= accept && (len > MAX_IN_L);
      err_zero_len <= accept && (len == '0) && !REMOVE_ZERO;
    end
  end

  // R10
  zero_flag_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    REMOVE_ZERO |-> !err_zero_len);

  // R11
  long_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !err_too_long);
endmodule

// File: rtl/job_splitter.sv
module job_splitter #(
  parameter int ADDR_W      = 32,
  parameter int ID_W        = 4,
  parameter int LEN_W       = 16,
  parameter int MAX_OUT     = 256,
  parameter int MAX_IN      = 65535,
  parameter bit REMOVE_ZERO = 1'b0,
  localparam int OFS_W      = $clog2(MAX_OUT),
  localparam int PW         = OFS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [ID_W-1:0]   in_id,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [PW-1:0]     out_len,
  output logic [ID_W-1:0]   out_id,
  output logic              err_too_long,
  output logic              err_zero_len
);
  logic              busy, accept, drop, load, fire, last;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  logic [ID_W-1:0]   cur_id;
  logic [PW-1:0]     piece;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign drop     = REMOVE_ZERO && (in_len == '0);
  assign load     = accept && !drop;
  assign fire     = out_valid && out_ready;

  jp_piece_calc #(.MAX_OUT(MAX_OUT), .LEN_W(LEN_W)) calc_i (
    .ofs(cur_addr[OFS_W-1:0]), .remain(remain), .piece(piece), .last(last)
  );

  jp_job_state #(.ADDR_W(ADDR_W), .ID_W(ID_W), .LEN_W(LEN_W), .MAX_OUT(MAX_OUT)) state_i (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_addr(in_addr), .ld_len(in_len),
    .ld_id(in_id), .fire(fire), .piece(piece), .last(last), .busy(busy),
    .cur_addr(cur_addr), .remain(remain), .cur_id(cur_id)
  );

  jp_err_flags #(.LEN_W(LEN_W), .MAX_IN(MAX_IN), .REMOVE_ZERO(REMOVE_ZERO)) err_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .len(in_len),
    .err_too_long(err_too_long), .err_zero_len(err_zero_len)
  );

  assign out_valid = busy;
  assign out_addr  = cur_addr;
  assign out_len   = piece;
  assign out_id    = cur_id;

  // R1
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_len <= PW'(MAX_OUT));

  // R2
  no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({1'b0, out_addr[OFS_W-1:0]} + out_len) <= PW'(MAX_OUT));

  // R6
  in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid && !in_ready);

  // R7
  out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_len) && $stable(out_id));

  // R8
  drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && drop |=> !out_valid);
endmodule

// File: tb/job_splitter_tb_top.sv
`timescale 1ns/1ps
module job_splitter_tb_top;
  localparam int AW = 14, IW = 4, LW = 7, MO = 16, MI = 100, PW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int bp_cnt = 0;

  logic          in_valid = 0, out_ready = 0;
  logic [AW-1:0] in_addr = '0;
  logic [LW-1:0] in_len = '0;
  logic [IW-1:0] in_id = '0;
  logic          in_ready, out_valid, err_long, err_zero;
  logic [AW-1:0] out_addr;
  logic [PW-1:0] out_len;
  logic [IW-1:0] out_id;

  logic          rz_in_valid = 0, rz_out_ready = 0;
  logic [AW-1:0] rz_in_addr = '0;
  logic [LW-1:0] rz_in_len = '0;
  logic          rz_in_ready, rz_out_valid, rz_err_long, rz_err_zero;
  logic [AW-1:0] rz_out_addr;
  logic [PW-1:0] rz_out_len;
  logic [IW-1:0] rz_out_id;

  job_splitter #(.ADDR_W(AW), .ID_W(IW), .LEN_W(LW), .MAX_OUT(MO), .MAX_IN(MI), .REMOVE_ZERO(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_len(in_len), .in_id(in_id), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_len(out_len), .out_id(out_id),
    .err_too_long(err_long), .err_zero_len(err_zero));

  job_splitter #(.ADDR_W(AW), .ID_W(IW), .LEN_W(LW), .MAX_OUT(MO), .MAX_IN(MI), .REMOVE_ZERO(1'b1)) dut_rz_i (
    .clk(clk), .rst_n(rst_n), .in_valid(rz_in_valid), .in_ready(rz_in_ready), .in_addr(rz_in_addr),
    .in_len(rz_in_len), .in_id(4'd9), .out_valid(rz_out_valid), .out_ready(rz_out_ready),
    .out_addr(rz_out_addr), .out_len(rz_out_len), .out_id(rz_out_id),
    .err_too_long(rz_err_long), .err_zero_len(rz_err_zero));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_job(input int a, input int l, input int id);
    int ea, rem, pc;
    bit done, rdy, stalled;
    @(negedge clk);
    chk(in_ready == 1'b1, "R6 idle ready", int'(in_ready), 1);
    in_valid = 1'b1; in_addr = AW'(a); in_len = LW'(l); in_id = IW'(id);
    @(negedge clk);
    in_valid = 1'b0;
    chk(err_zero == (l == 0), "R9 zero flag", int'(err_zero), int'(l == 0));
    chk(err_long == (l > MI), "R11 long flag", int'(err_long), int'(l > MI));
    ea = a; rem = l; done = 0; stalled = 0;
    while (!done) begin
      pc = MO - (ea % MO);
      if (rem < pc) pc = rem;
      chk(out_valid == 1'b1, stalled ? "R7 valid held" : "R6 piece valid", int'(out_valid), 1);
      chk(int'(out_addr) == ea, stalled ? "R7 addr held" : "R3/R4 addr", int'(out_addr), ea);
      chk(int'(out_len) == pc, stalled ? "R7 len held" : "R1/R3/R4 len", int'(out_len), pc);
      chk(int'(out_id) == id, "R5 id", int'(out_id), id);
      chk(in_ready == 1'b0, "R6 busy", int'(in_ready), 0);
      chk((int'(out_addr) % 4096) + int'(out_len) <= 4096, "R2 4K", int'(out_addr), ea);
      bp_cnt++;
      rdy = (bp_cnt % 3) != 2;
      out_ready = rdy;
      @(negedge clk);
      stalled = !rdy;
      if (rdy) begin
        ea += pc; rem -= pc;
        done = (rem == 0);
      end
    end
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R4 no extra piece", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R6 released", int'(in_ready), 1);
    chk(err_zero == 1'b0 && err_long == 1'b0, "R9/R11 pulse width", int'({err_zero, err_long}), 0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 during reset
    chk(out_valid == 0 && in_ready == 1 && err_long == 0 && err_zero == 0, "R12 reset",
        int'({out_valid, in_ready, err_long, err_zero}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rz_out_valid == 0 && rz_in_ready == 1 && rz_err_zero == 0, "R12 after reset",
        int'({rz_out_valid, rz_in_ready, rz_err_zero}), 2);

    for (int base = 0; base < 2; base++) begin
      for (int o = 0; o < 32; o++) begin
        for (int l = 0; l <= 44; l++) begin
          int len;
          len = (l <= 40) ? l : ((l == 41) ? 99 : (l == 42) ? 100 : (l == 43) ? 101 : 127);
          run_job((base == 0 ? 0 : 4096 - 32) + o, len, (o + l) % 16);
        end
      end
    end
    // example: address 128, length 256 is beyond LEN_W here; the scaled case is offset 8, length 16
    run_job(8, 16, 3);

    // R8, R10: zero-length job dropped
    @(negedge clk);
    rz_in_valid = 1'b1; rz_in_addr = AW'(5); rz_in_len = '0;
    @(negedge clk);
    rz_in_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(rz_out_valid == 1'b0, "R8 no output", int'(rz_out_valid), 0);
      chk(rz_in_ready == 1'b1, "R8 ready kept", int'(rz_in_ready), 1);
      chk(rz_err_zero == 1'b0, "R10 flag off", int'(rz_err_zero), 0);
      @(negedge clk);
    end
    rz_in_valid = 1'b1; rz_in_addr = AW'(5); rz_in_len = LW'(20);
    @(negedge clk);
    rz_in_valid = 1'b0;
    chk(rz_out_valid && int'(rz_out_addr) == 5 && int'(rz_out_len) == 11, "R8 normal job first",
        int'(rz_out_len), 11);
    rz_out_ready = 1'b1;
    @(negedge clk);
    chk(rz_out_valid && int'(rz_out_addr) == 16 && int'(rz_out_len) == 9, "R8 normal job last",
        int'(rz_out_len), 9);
    @(negedge clk);
    rz_out_ready = 1'b0;
    chk(!rz_out_valid && rz_in_ready, "R8 idle", int'(rz_out_valid), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule